// File: doc/BRIEF.md
# Single-Instruction Repeat Controller

This block sequences instruction fetch so that one instruction can be run many times in a row with no loop overhead. A decode stage raises a repeat command along with a count operand. The controller then keeps the program counter on the word that follows the command, so that word is issued again on every cycle. A hidden counter runs down in parallel with those issues, and when it expires the program counter moves on. Loading the counter, testing it for the end and branching back all take place in the same cycles as the repeated instruction, so no cycle is spent on loop bookkeeping.

The controller drives the address for a synchronous instruction memory (`fetch_addr`, the address that will be issued on the next cycle). It also reports the address being issued now, a per-cycle issue strobe and a flag that is high while repetitions are in progress. The repeated instruction issues once per repetition, so any post-increment addressing it performs advances on every pass. Only one instruction can be repeated. Block loops, nesting and interruption of a repeat are not supported.

Top module: `rptc_top`

## Requirements
- R1: A synchronous active-high `rst` leaves `pc` at 0 with `issue_valid` and `rpt_active` low, and clears any repeat in progress. On the first cycle after `rst` falls, address 0 issues.
- R2: When no repeat is in progress, every cycle after the first issue has `issue_valid` high and `pc` one greater than in the cycle before, modulo 2^PC_W.
- R3: `rpt_cmd` counts only in a cycle where `issue_valid` is high and `rpt_active` is low. The command uses its own issue slot at address P. On the next cycle, address P+1 issues with `rpt_active` high.
- R4: For an operand N, the word at P+1 issues N+1 times on consecutive cycles with `issue_valid` high on each one. There are no bubbles, so an instruction that increments an address register on each issue advances it N+1 times.
- R5: `rpt_active` is high in exactly the N+1 cycles in which the repeated word issues, from the first repetition to the last.
- R6: On the cycle after the last repetition, address P+2 issues and `rpt_active` is low.
- R7: A `rpt_cmd` raised while `rpt_active` is high is ignored. The repeat that is running keeps its original count.
- R8: An operand of 0 makes the following word issue exactly once, with `rpt_active` high for that single cycle.
- R9: The largest operand, 2^CNT_W-1, gives 2^CNT_W repetitions.
- R10: A repeat command located at P+2, directly after a finished repeat, starts a new repeat with no extra cycle.
- R11: In every cycle, `fetch_addr` equals the `pc` that will issue on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_cmd | input | 1 | The word issuing this cycle is a repeat command |
| rpt_count | input | CNT_W | Repeat operand; executions = operand + 1 |
| fetch_addr | output | PC_W | Address to present to the synchronous instruction memory |
| pc | output | PC_W | Address of the word issuing this cycle |
| issue_valid | output | 1 | A word issues this cycle |
| rpt_active | output | 1 | The issuing word is a repetition |

## Verification
Every result appears in the cycle after the one in which it is caused. A repeat command seen at one clock edge raises `rpt_active` at the next edge, and it changes `pc` to P+1 at that same edge. The exit happens one edge after the cycle in which the counter reads zero. The instruction word reaches the decoder one edge after `fetch_addr` presents its address. The bench therefore records `pc`, `issue_valid`, `rpt_active` and `fetch_addr` at every falling edge and compares each cycle with a trace computed from the program image. It compares `fetch_addr` against the expected address of the following cycle. Counts of active cycles and of address-register increments are taken from the same samples.

// File: rtl/rptc_pkg.sv
package rptc_pkg;

    // Action applied to the hidden repeat counter this cycle
    typedef enum logic [1:0] {
        CNT_KEEP = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_op_e;

    // Action applied to the program counter this cycle
    typedef enum logic {
        PC_STEP = 1'b0,
        PC_HOLD = 1'b1
    } pc_op_e;

endpackage

// File: rtl/rptc_counter.sv
module rptc_counter
    import rptc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (op)
            CNT_LOAD: state_d.cnt = load_val;
            CNT_DEC:  state_d.cnt = state_q.cnt - CNT_W'(1);
            default:  state_d.cnt = state_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign zero = (state_q.cnt == '0);

endmodule

// File: rtl/rptc_pcgen.sv
module rptc_pcgen
    import rptc_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  pc_op_e          op,
    output logic [PC_W-1:0] pc,
    output logic            valid,
    output logic [PC_W-1:0] next_pc
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            valid;
    } pc_state_t;

    pc_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b1;
        if (state_q.valid && (op == PC_STEP))
            state_d.pc = state_q.pc + PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign pc      = state_q.pc;
    assign valid   = state_q.valid;
    assign next_pc = state_d.pc;

endmodule

// File: rtl/rptc_seq.sv
module rptc_seq
    import rptc_pkg::*;
(
    input  logic    issue_valid,
    input  logic    rpt_cmd,
    input  logic    active_q,
    input  logic    cnt_zero,
    output cnt_op_e cnt_op,
    output pc_op_e  pc_op,
    output logic    active_d
);

    always_comb begin
        cnt_op   = CNT_KEEP;
        pc_op    = PC_STEP;
        active_d = active_q;
        if (active_q) begin
            if (cnt_zero) begin
                active_d = 1'b0;
            end else begin
                cnt_op = CNT_DEC;
                pc_op  = PC_HOLD;
            end
        end else if (issue_valid && rpt_cmd) begin
            cnt_op   = CNT_LOAD;
            active_d = 1'b1;
        end
    end

endmodule

// File: rtl/rptc_top.sv
module rptc_top
    import rptc_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rpt_cmd,
    input  logic [CNT_W-1:0] rpt_count,
    output logic [PC_W-1:0]  fetch_addr,
    output logic [PC_W-1:0]  pc,
    output logic             issue_valid,
    output logic             rpt_active
);

    typedef struct packed {
        logic active;
    } top_state_t;

    top_state_t state_d, state_q;
    cnt_op_e    cnt_op;
    pc_op_e     pc_op;
    logic       cnt_zero;
    logic       active_nx;

    rptc_seq u_seq (
        .issue_valid (issue_valid),
        .rpt_cmd     (rpt_cmd),
        .active_q    (state_q.active),
        .cnt_zero    (cnt_zero),
        .cnt_op      (cnt_op),
        .pc_op       (pc_op),
        .active_d    (active_nx)
    );

    rptc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .op       (cnt_op),
        .load_val (rpt_count),
        .zero     (cnt_zero)
    );

    rptc_pcgen #(.PC_W(PC_W)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .op      (pc_op),
        .pc      (pc),
        .valid   (issue_valid),
        .next_pc (fetch_addr)
    );

    always_comb begin
        state_d        = state_q;
        state_d.active = active_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign rpt_active = state_q.active;

endmodule

// File: rtl/rptc_chk.sv
module rptc_chk #(
    parameter int PC_W = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            rpt_cmd,
    input logic [PC_W-1:0] pc,
    input logic            issue_valid,
    input logic            rpt_active,
    input logic            cnt_zero
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc == '0 && !issue_valid && !rpt_active));

    // R2
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !rpt_active) |=> (issue_valid && pc == PC_W'($past(pc) + 1'b1)));

    // R3
    repeat_start_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && rpt_cmd && !rpt_active) |=> (rpt_active && pc == PC_W'($past(pc) + 1'b1)));

    // R4
    repeat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rpt_active && !cnt_zero) |=> (rpt_active && issue_valid && $stable(pc)));

    // R6
    repeat_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (rpt_active && cnt_zero) |=> (!rpt_active && pc == PC_W'($past(pc) + 1'b1)));

    // R7
    ignore_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (rpt_active && rpt_cmd && !cnt_zero) |=> $stable(pc));

endmodule

bind rptc_top rptc_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rpt_cmd     (rpt_cmd),
    .pc          (pc),
    .issue_valid (issue_valid),
    .rpt_active  (rpt_active),
    .cnt_zero    (cnt_zero)
);

// File: tb/tb_rptc_top.sv
`timescale 1ns/1ps
module tb_rptc_top;

    localparam int PC_W  = 12;
    localparam int CNT_W = 8;
    localparam int MAXT  = 600;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rpt_cmd;
    logic [CNT_W-1:0] rpt_count;
    logic [PC_W-1:0]  fetch_addr;
    logic [PC_W-1:0]  pc;
    logic             issue_valid;
    logic             rpt_active;

    // Program word: bit 15 = repeat command, bits 7:0 = operand,
    // bit 14 = instruction post-increments an address register.
    logic [15:0] mem [0:255];
    logic [15:0] instr_q;

    int n_chk = 0;
    int n_fail = 0;

    int exp_pc  [0:MAXT];
    bit exp_act [0:MAXT];
    int cap_pc  [0:MAXT];
    bit cap_act [0:MAXT];
    int ar_count;

    always #2.5 clk = ~clk;

    rptc_top #(.PC_W(PC_W), .CNT_W(CNT_W)) dut (
        .clk         (clk),
        .rst         (rst),
        .rpt_cmd     (rpt_cmd),
        .rpt_count   (rpt_count),
        .fetch_addr  (fetch_addr),
        .pc          (pc),
        .issue_valid (issue_valid),
        .rpt_active  (rpt_active)
    );

    always @(posedge clk) instr_q <= mem[fetch_addr[7:0]];
    assign rpt_cmd   = instr_q[15];
    assign rpt_count = instr_q[7:0];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    // Expected issue sequence derived from the program image
    task automatic build_expected(input int len);
        int n = 0;
        int a = 0;
        while (n <= len) begin
            exp_pc[n] = a; exp_act[n] = 1'b0; n++;
            if (mem[a[7:0]][15]) begin
                for (int k = 0; k <= int'(mem[a[7:0]][7:0]); k++) begin
                    if (n <= len) begin
                        exp_pc[n] = a + 1; exp_act[n] = 1'b1; n++;
                    end
                end
                a = a + 2;
            end else begin
                a = a + 1;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(pc == '0, "R1", "pc in reset", int'(pc), 0);
        chk(!issue_valid && !rpt_active, "R1", "valid/active in reset",
            int'({issue_valid, rpt_active}), 0);
        rst = 1'b0;
    endtask

    task automatic run_trace(input int len, input string req);
        int pc_bad = 0, act_bad = 0, val_bad = 0, fa_bad = 0;
        int p_a = 0, p_e = 0, f_a = 0, f_e = 0;
        build_expected(len);
        ar_count = 0;
        for (int n = 0; n < len; n++) begin
            @(posedge clk);
            @(negedge clk);
            cap_pc[n]  = int'(pc);
            cap_act[n] = rpt_active;
            if (issue_valid && instr_q[14]) ar_count++;
            if (int'(pc) != exp_pc[n]) begin
                if (pc_bad == 0) begin p_a = int'(pc); p_e = exp_pc[n]; end
                pc_bad++;
            end
            if (rpt_active != exp_act[n]) act_bad++;
            if (!issue_valid) val_bad++;
            if (int'(fetch_addr) != exp_pc[n+1]) begin
                if (fa_bad == 0) begin f_a = int'(fetch_addr); f_e = exp_pc[n+1]; end
                fa_bad++;
            end
        end
        chk(pc_bad == 0, req, "pc trace first mismatch", p_a, p_e);
        chk(act_bad == 0, req, "rpt_active mismatches", act_bad, 0);
        chk(val_bad == 0, req, "cycles without issue", val_bad, 0);
        chk(fa_bad == 0, "R11", "fetch_addr vs next pc", f_a, f_e);
    endtask

    function automatic int active_cycles(input int len);
        int c = 0;
        for (int n = 0; n < len; n++) if (cap_act[n]) c++;
        return c;
    endfunction

    task automatic t_reset();
        clear_mem();
        do_reset();
        @(posedge clk); @(negedge clk);
        chk(pc == '0 && issue_valid, "R1", "first issue after reset", int'(pc), 0);
    endtask

    task automatic t_linear();
        clear_mem();
        do_reset();
        run_trace(20, "R2");
        chk(cap_pc[19] == 19, "R2", "pc after 20 cycles", cap_pc[19], 19);
    endtask

    task automatic t_rep99();
        clear_mem();
        mem[3] = 16'h8000 | 16'd99;
        mem[4] = 16'h4000;
        do_reset();
        run_trace(110, "R3");
        chk(cap_pc[4] == 4 && cap_act[4], "R3", "first repetition slot", cap_pc[4], 4);
        chk(ar_count == 100, "R4", "address-register increments", ar_count, 100);
        chk(active_cycles(110) == 100, "R5", "active cycles", active_cycles(110), 100);
        chk(cap_act[103] && !cap_act[3], "R5", "active bounds", int'(cap_act[103]), 1);
        chk(cap_pc[104] == 5 && !cap_act[104], "R6", "pc after exit", cap_pc[104], 5);
    endtask

    task automatic t_rep0();
        clear_mem();
        mem[2] = 16'h8000;
        mem[3] = 16'h4000;
        do_reset();
        run_trace(10, "R8");
        chk(ar_count == 1, "R8", "single execution", ar_count, 1);
        chk(active_cycles(10) == 1, "R8", "active cycles", active_cycles(10), 1);
        chk(cap_pc[4] == 4, "R8", "pc after single rep", cap_pc[4], 4);
    endtask

    task automatic t_repmax();
        clear_mem();
        mem[0] = 16'h8000 | 16'd255;
        mem[1] = 16'h4000;
        do_reset();
        run_trace(265, "R9");
        chk(ar_count == 256, "R9", "max-count executions", ar_count, 256);
        chk(cap_pc[257] == 2 && !cap_act[257], "R9", "exit pc", cap_pc[257], 2);
    endtask

    task automatic t_ignore();
        clear_mem();
        mem[1] = 16'h8000 | 16'd5;
        mem[2] = 16'hC000 | 16'd50;
        do_reset();
        run_trace(20, "R7");
        chk(ar_count == 6, "R7", "repetitions with inner command", ar_count, 6);
        chk(cap_pc[8] == 3 && !cap_act[8], "R7", "pc after repeat", cap_pc[8], 3);
        chk(active_cycles(20) == 6, "R7", "active cycles", active_cycles(20), 6);
    endtask

    task automatic t_chain();
        clear_mem();
        mem[0] = 16'h8000 | 16'd2;
        mem[1] = 16'h4000;
        mem[2] = 16'h8000 | 16'd3;
        mem[3] = 16'h4000;
        do_reset();
        run_trace(14, "R10");
        chk(cap_pc[4] == 2 && !cap_act[4], "R10", "second command slot", cap_pc[4], 2);
        chk(cap_pc[5] == 3 && cap_act[5], "R10", "second repeat starts", cap_pc[5], 3);
        chk(ar_count == 7, "R10", "total repetitions", ar_count, 7);
    endtask

    task automatic t_midreset();
        clear_mem();
        mem[0] = 16'h8000 | 16'd200;
        mem[1] = 16'h4000;
        do_reset();
        run_trace(20, "R4");
        do_reset();
        run_trace(210, "R1");
        chk(ar_count == 201, "R1", "count after mid-repeat reset", ar_count, 201);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_linear();
        t_rep99();
        t_rep0();
        t_repmax();
        t_ignore();
        t_chain();
        t_midreset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule